// File: doc/BRIEF.md
# FIFO status and interrupt controller

This block buffers data words between a register-mapped host port and a serial shift engine. The transmit FIFO is filled by host writes and drained by the engine. The receive FIFO is filled by the engine and drained by host reads. The host can read the fill level of each FIFO and a five-bit status word at any time.

Interrupts come from five sources:
- a transmit-low condition, set when the transmit level is at or below a threshold;
- a receive-threshold condition, set when the receive level is strictly above its threshold;
- three sticky error flags: transmit overflow, receive underflow and receive overflow.

The host reads the raw sources, a mask and the masked pending view. The error flags are cleared by writing ones to a clear register. A single level-high interrupt line is asserted whenever any masked source is active.

An enable bit gates the whole datapath. While the bit is clear, both FIFOs are kept empty and the threshold registers accept writes. While it is set, the thresholds are frozen, so the interrupt conditions cannot shift during a transfer.

Top module: `sfi_top`

## Requirements
- R1: Register word addresses on `reg_addr` are as follows.
  - 0: control, enable in bit 0
  - 1: transmit threshold
  - 2: receive threshold
  - 3: transmit level
  - 4: receive level
  - 5: status
  - 6: interrupt mask
  - 7: pending, which is raw AND mask
  - 8: raw interrupt
  - 9: clear, write-only
  - 10: transmit data, write-only
  - 11: receive data, a read that pops
  - Write-only and unused addresses read as zero. `reg_rdata` is valid, combinationally, only during `reg_rd`.
- R2: After reset the following hold:
  - the enable bit, both thresholds and the mask are zero;
  - both levels are zero;
  - status reads 0x0C;
  - raw reads 0x01;
  - `irq` is low.
- R3: While enabled, a write to transmit data appends the low DATA_W bits. `eng_tx_data` shows the oldest word, or zero when the FIFO is empty, and `eng_tx_pop` removes it. `eng_tx_avail` is high when the transmit FIFO is not empty. `eng_rx_push` appends `eng_rx_data`, and receive-data reads return words in arrival order. Both FIFOs hold DEPTH words, and both levels are readable at any time.
- R4: Status bits are: bit 0 mirrors `eng_busy`, bit 1 transmit full, bit 2 transmit empty, bit 3 receive empty, bit 4 receive full.
- R5: An enabled write to a full transmit FIFO is dropped, the level is unchanged, and raw bit 1 (transmit overflow) is set and stays set.
- R6: A receive-data read while the receive FIFO is empty returns zero and sets sticky raw bit 2 (receive underflow).
- R7: An enabled engine push into a full receive FIFO is dropped and sets sticky raw bit 3 (receive overflow).
- R8: Raw bit 4 is high exactly when the receive level is greater than the receive threshold.
- R9: Raw bit 0 is high exactly when the transmit level is at most the transmit threshold.
- R10: The interrupt output behaves as follows.
  - Pending equals raw AND mask, bit for bit.
  - `irq` is the OR of the pending bits.
  - A zero mask holds `irq` low.
- R11: A write to the clear register acts on the sticky flags.
  - Bit 0 clears all three sticky flags.
  - Bit 1 clears receive underflow.
  - Bit 2 clears receive overflow.
  - Bit 3 clears transmit overflow.
  - An error event in the same cycle as its clear leaves the flag set.
  - Raw bits 0 and 4 are unaffected.
- R12: While the enable bit is clear:
  - both FIFOs are emptied at the next clock edge;
  - transmit-data writes and engine pushes are ignored, and neither sets an overflow flag.
- R13: Writes to either threshold register are ignored while the enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational during `reg_rd` |
| eng_busy | input | 1 | Busy indication from the shift engine |
| eng_tx_pop | input | 1 | Engine takes the transmit head word |
| eng_tx_data | output | DATA_W | Transmit head word |
| eng_tx_avail | output | 1 | Transmit FIFO not empty |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DATA_W | Received word |
| fifo_en | output | 1 | Enable bit, for the engine |
| irq | output | 1 | Level-high interrupt |

## Verification
The hardest situation to reach is a clear-register write in the same cycle as a new error event on the flag being cleared. It needs a FIFO already at DEPTH and an engine push that coincides with the host write. The bench fills the receive FIFO to capacity with directed pushes, then issues the clear together with one more push, and reads raw to confirm that the flag survived.

Random traffic follows, with push and pop rates biased so both FIFOs repeatedly reach full and empty. Enable toggles and threshold writes are interleaved in the same stream. As a result, flushes, locked thresholds and set/clear collisions recur under a reference model.

// File: rtl/sfi_pkg.sv
`timescale 1ns/1ps
package sfi_pkg;

    localparam int REG_AW   = 4;
    localparam int REG_DW   = 32;
    localparam int IRQ_N    = 5;
    localparam int CLR_N    = 4;
    localparam int N_STICKY = 3;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL  = 4'd0,
        A_TXTHR = 4'd1,
        A_RXTHR = 4'd2,
        A_TXLVL = 4'd3,
        A_RXLVL = 4'd4,
        A_STAT  = 4'd5,
        A_MASK  = 4'd6,
        A_PEND  = 4'd7,
        A_RAW   = 4'd8,
        A_CLR   = 4'd9,
        A_TXDAT = 4'd10,
        A_RXDAT = 4'd11
    } reg_addr_e;

    // bit 4 down to bit 0
    typedef struct packed {
        logic rx_thr;
        logic rx_ovf;
        logic rx_udf;
        logic tx_ovf;
        logic tx_low;
    } irq_vec_t;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_vec_t;

    // bit 3 down to bit 0
    typedef struct packed {
        logic tx_ovf;
        logic rx_ovf;
        logic rx_udf;
        logic all;
    } clr_vec_t;

    // a fresh event wins over a clear in the same cycle
    function automatic logic sticky_next(input logic q, input logic set, input logic clr);
        return set | (q & ~clr);
    endfunction

endpackage

// File: rtl/sfi_fifo.sv
`timescale 1ns/1ps
module sfi_fifo #(
    parameter  int DEPTH  = 32,
    parameter  int DATA_W = 16,
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [LVL_W-1:0]  level,
    output logic              full,
    output logic              empty,
    output logic              drop
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [LVL_W-1:0]  cnt;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == LVL_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign drop    = push && full && !flush;
    assign level   = cnt;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/sfi_irq.sv
`timescale 1ns/1ps
module sfi_irq
    import sfi_pkg::*;
#(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] tx_lvl,
    input  logic [LVL_W-1:0] rx_lvl,
    input  logic [LVL_W-1:0] tx_thr,
    input  logic [LVL_W-1:0] rx_thr,
    input  logic             set_tx_ovf,
    input  logic             set_rx_udf,
    input  logic             set_rx_ovf,
    input  logic             clr_wr,
    input  clr_vec_t         clr,
    input  irq_vec_t         mask,
    output irq_vec_t         raw,
    output irq_vec_t         pend,
    output logic             irq
);

    // index 0: tx overflow, 1: rx underflow, 2: rx overflow
    logic [N_STICKY-1:0] st_q, st_set, st_clr;

    assign st_set = {set_rx_ovf, set_rx_udf, set_tx_ovf};
    assign st_clr = {clr_wr && (clr.all || clr.rx_ovf),
                     clr_wr && (clr.all || clr.rx_udf),
                     clr_wr && (clr.all || clr.tx_ovf)};

    for (genvar i = 0; i < N_STICKY; i++) begin : g_sticky
        logic q;
        always_ff @(posedge clk) begin
            if (rst) q <= 1'b0;
            else     q <= sticky_next(q, st_set[i], st_clr[i]);
        end
        assign st_q[i] = q;
    end

    always_comb begin
        raw.tx_low = (tx_lvl <= tx_thr);
        raw.tx_ovf = st_q[0];
        raw.rx_udf = st_q[1];
        raw.rx_ovf = st_q[2];
        raw.rx_thr = (rx_lvl > rx_thr);
    end

    assign pend = irq_vec_t'(raw & mask);
    assign irq  = |pend;

endmodule

// File: rtl/sfi_regfile.sv
`timescale 1ns/1ps
module sfi_regfile
    import sfi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LVL_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic [LVL_W-1:0]  tx_lvl,
    input  logic [LVL_W-1:0]  rx_lvl,
    input  stat_vec_t         stat,
    input  irq_vec_t          raw,
    input  irq_vec_t          pend,
    input  logic [DATA_W-1:0] rx_head,
    output logic              en,
    output logic [LVL_W-1:0]  tx_thr,
    output logic [LVL_W-1:0]  rx_thr,
    output irq_vec_t          mask,
    output logic              tx_push,
    output logic [DATA_W-1:0] tx_wdata,
    output logic              rx_pop,
    output logic              clr_wr,
    output clr_vec_t          clr
);

    reg_addr_e sel;
    logic      unused_wdata;

    assign sel          = reg_addr_e'(reg_addr);
    assign unused_wdata = ^reg_wdata;

    assign tx_push  = reg_wr && (sel == A_TXDAT);
    assign tx_wdata = reg_wdata[DATA_W-1:0];
    assign rx_pop   = reg_rd && (sel == A_RXDAT);
    assign clr_wr   = reg_wr && (sel == A_CLR);
    assign clr      = clr_vec_t'(reg_wdata[CLR_N-1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            en     <= 1'b0;
            tx_thr <= '0;
            rx_thr <= '0;
            mask   <= '0;
        end else if (reg_wr) begin
            case (sel)
                A_CTRL:  en <= reg_wdata[0];
                A_TXTHR: if (!en) tx_thr <= reg_wdata[LVL_W-1:0];
                A_RXTHR: if (!en) rx_thr <= reg_wdata[LVL_W-1:0];
                A_MASK:  mask <= irq_vec_t'(reg_wdata[IRQ_N-1:0]);
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (sel)
                A_CTRL:  reg_rdata = REG_DW'(en);
                A_TXTHR: reg_rdata = REG_DW'(tx_thr);
                A_RXTHR: reg_rdata = REG_DW'(rx_thr);
                A_TXLVL: reg_rdata = REG_DW'(tx_lvl);
                A_RXLVL: reg_rdata = REG_DW'(rx_lvl);
                A_STAT:  reg_rdata = {{(REG_DW-IRQ_N){1'b0}}, stat};
                A_MASK:  reg_rdata = {{(REG_DW-IRQ_N){1'b0}}, mask};
                A_PEND:  reg_rdata = {{(REG_DW-IRQ_N){1'b0}}, pend};
                A_RAW:   reg_rdata = {{(REG_DW-IRQ_N){1'b0}}, raw};
                A_RXDAT: reg_rdata = REG_DW'(rx_head);
                default: reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/sfi_top.sv
`timescale 1ns/1ps
module sfi_top
    import sfi_pkg::*;
#(
    parameter  int DEPTH  = 32,
    parameter  int DATA_W = 16,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    input  logic              eng_busy,
    input  logic              eng_tx_pop,
    output logic [DATA_W-1:0] eng_tx_data,
    output logic              eng_tx_avail,
    input  logic              eng_rx_push,
    input  logic [DATA_W-1:0] eng_rx_data,
    output logic              fifo_en,
    output logic              irq
);

    logic [LVL_W-1:0]  tx_lvl, rx_lvl, tx_thr, rx_thr;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_drop, rx_drop;
    logic [DATA_W-1:0] rx_head, tx_wdata;
    logic              tx_push, rx_pop, en, clr_wr;
    clr_vec_t          clr;
    irq_vec_t          mask, raw, pend;
    stat_vec_t         stat;

    always_comb begin
        stat.busy     = eng_busy;
        stat.tx_full  = tx_full;
        stat.tx_empty = tx_empty;
        stat.rx_empty = rx_empty;
        stat.rx_full  = rx_full;
    end

    assign fifo_en      = en;
    assign eng_tx_avail = !tx_empty;

    sfi_regfile #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .tx_lvl   (tx_lvl),
        .rx_lvl   (rx_lvl),
        .stat     (stat),
        .raw      (raw),
        .pend     (pend),
        .rx_head  (rx_head),
        .en       (en),
        .tx_thr   (tx_thr),
        .rx_thr   (rx_thr),
        .mask     (mask),
        .tx_push  (tx_push),
        .tx_wdata (tx_wdata),
        .rx_pop   (rx_pop),
        .clr_wr   (clr_wr),
        .clr      (clr)
    );

    sfi_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .flush    (!en),
        .push     (tx_push),
        .push_data(tx_wdata),
        .pop      (eng_tx_pop),
        .head     (eng_tx_data),
        .level    (tx_lvl),
        .full     (tx_full),
        .empty    (tx_empty),
        .drop     (tx_drop)
    );

    sfi_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .flush    (!en),
        .push     (eng_rx_push),
        .push_data(eng_rx_data),
        .pop      (rx_pop),
        .head     (rx_head),
        .level    (rx_lvl),
        .full     (rx_full),
        .empty    (rx_empty),
        .drop     (rx_drop)
    );

    sfi_irq #(.LVL_W(LVL_W)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .tx_lvl    (tx_lvl),
        .rx_lvl    (rx_lvl),
        .tx_thr    (tx_thr),
        .rx_thr    (rx_thr),
        .set_tx_ovf(tx_drop),
        .set_rx_udf(rx_pop && rx_empty),
        .set_rx_ovf(rx_drop),
        .clr_wr    (clr_wr),
        .clr       (clr),
        .mask      (mask),
        .raw       (raw),
        .pend      (pend),
        .irq       (irq)
    );

endmodule

// File: rtl/sfi_chk.sv
`timescale 1ns/1ps
module sfi_chk
    import sfi_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int LVL_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_AW-1:0] reg_addr,
    input logic [REG_DW-1:0] reg_rdata,
    input logic              fifo_en,
    input logic              irq,
    input logic [LVL_W-1:0]  tx_lvl,
    input logic [LVL_W-1:0]  rx_lvl,
    input logic              tx_full,
    input logic              rx_empty,
    input logic [LVL_W-1:0]  tx_thr,
    input logic [LVL_W-1:0]  rx_thr,
    input irq_vec_t          raw,
    input irq_vec_t          mask
);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LVL_W'(DEPTH)) && (rx_lvl <= LVL_W'(DEPTH)));

    p_tx_ovf_r5: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 4'd10 && fifo_en && tx_full) |=> raw.tx_ovf);

    p_udf_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 4'd11 && rx_empty) |-> (reg_rdata == '0));

    p_udf_flag_r6: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 4'd11 && rx_empty) |=> raw.rx_udf);

    p_mask_zero_r10: assert property (@(posedge clk) disable iff (rst)
        ({mask} == 5'd0) |-> !irq);

    p_rx_thr_irq_r10: assert property (@(posedge clk) disable iff (rst)
        (mask.rx_thr && (rx_lvl > rx_thr)) |-> irq);

    p_flush_r12: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |=> (tx_lvl == '0 && rx_lvl == '0));

    p_thr_lock_r13: assert property (@(posedge clk) disable iff (rst)
        fifo_en |=> ($stable(tx_thr) && $stable(rx_thr)));

endmodule

bind sfi_top sfi_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .fifo_en  (fifo_en),
    .irq      (irq),
    .tx_lvl   (tx_lvl),
    .rx_lvl   (rx_lvl),
    .tx_full  (tx_full),
    .rx_empty (rx_empty),
    .tx_thr   (tx_thr),
    .rx_thr   (rx_thr),
    .raw      (raw),
    .mask     (mask)
);

// File: tb/sfi_top_tb.sv
`timescale 1ns/1ps
module sfi_top_tb;

    localparam int DEPTH = 32;
    localparam int DW    = 16;

    // R1 address map
    localparam logic [3:0] A_CTRL = 4'd0, A_TXTHR = 4'd1, A_RXTHR = 4'd2, A_TXLVL = 4'd3,
                           A_RXLVL = 4'd4, A_STAT = 4'd5, A_MASK = 4'd6, A_PEND = 4'd7,
                           A_RAW = 4'd8, A_CLR = 4'd9, A_TXDAT = 4'd10, A_RXDAT = 4'd11;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          eng_busy = 1'b0, eng_tx_pop = 1'b0, eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic [DW-1:0] eng_tx_data;
    logic          eng_tx_avail, fifo_en, irq;

    always #2.5 clk = ~clk;

    sfi_top #(.DEPTH(DEPTH), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_busy(eng_busy),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .fifo_en(fifo_en), .irq(irq)
    );

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // reference model
    bit            m_en = 0;
    logic [5:0]    m_txthr = '0, m_rxthr = '0;
    logic [4:0]    m_mask = '0;
    bit            m_txovf = 0, m_rxudf = 0, m_rxovf = 0;
    logic [DW-1:0] tq[$];
    logic [DW-1:0] rq[$];
    bit            busy = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [4:0] m_raw();
        return {rq.size() > int'(m_rxthr), m_rxovf, m_rxudf, m_txovf, tq.size() <= int'(m_txthr)};
    endfunction

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            A_CTRL:  return {31'd0, m_en};
            A_TXTHR: return {26'd0, m_txthr};
            A_RXTHR: return {26'd0, m_rxthr};
            A_TXLVL: return 32'(tq.size());
            A_RXLVL: return 32'(rq.size());
            A_STAT:  return {27'd0, rq.size() == DEPTH, rq.size() == 0, tq.size() == 0,
                             tq.size() == DEPTH, busy};
            A_MASK:  return {27'd0, m_mask};
            A_PEND:  return {27'd0, m_raw() & m_mask};
            A_RAW:   return {27'd0, m_raw()};
            A_RXDAT: return (rq.size() != 0) ? 32'(rq[0]) : 32'd0;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            A_TXLVL, A_RXLVL, A_RXDAT: return "R3";
            A_STAT:                    return "R4";
            A_RAW:                     return "R8/R9 raw";
            A_PEND, A_MASK:            return "R10";
            A_TXTHR, A_RXTHR:          return "R13";
            A_CTRL:                    return "R12";
            default:                   return "R1";
        endcase
    endfunction

    // drives one cycle from a negedge, checks outputs before the edge, advances the model
    task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] d,
                        input bit tpop, input bit rpush, input logic [DW-1:0] rdat,
                        input string tag = "");
        bit s_tx, s_udf, s_ovf;
        bit c_all;
        reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
        eng_tx_pop = tpop; eng_rx_push = rpush; eng_rx_data = rdat; eng_busy = busy;
        #1;
        check("R10 irq", {31'd0, irq}, {31'd0, |(m_raw() & m_mask)});
        check("R3 tx head", 32'(eng_tx_data), (tq.size() != 0) ? 32'(tq[0]) : 32'd0);
        check("R3 tx avail", {31'd0, eng_tx_avail}, {31'd0, tq.size() != 0});
        if (rd) check((tag == "") ? tag_of(a) : tag, reg_rdata, m_read(a));
        s_tx  = wr && a == A_TXDAT && m_en && tq.size() == DEPTH;
        s_udf = rd && a == A_RXDAT && rq.size() == 0;
        s_ovf = rpush && m_en && rq.size() == DEPTH;
        if (!m_en) begin
            tq.delete();
            rq.delete();
        end else begin
            bit tpush_ok = wr && a == A_TXDAT && tq.size() < DEPTH;
            bit rpush_ok = rpush && rq.size() < DEPTH;
            if (tpop && tq.size() != 0) void'(tq.pop_front());
            if (rd && a == A_RXDAT && rq.size() != 0) void'(rq.pop_front());
            if (tpush_ok) tq.push_back(d[DW-1:0]);
            if (rpush_ok) rq.push_back(rdat);
        end
        c_all = wr && a == A_CLR && d[0];
        m_txovf = s_tx  | (m_txovf & ~(c_all | (wr && a == A_CLR && d[3])));
        m_rxudf = s_udf | (m_rxudf & ~(c_all | (wr && a == A_CLR && d[1])));
        m_rxovf = s_ovf | (m_rxovf & ~(c_all | (wr && a == A_CLR && d[2])));
        if (wr) begin
            case (a)
                A_TXTHR: if (!m_en) m_txthr = d[5:0];
                A_RXTHR: if (!m_en) m_rxthr = d[5:0];
                A_MASK:  m_mask = d[4:0];
                A_CTRL:  m_en = d[0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        step(1, 0, a, d, 0, 0, '0);
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        step(0, 1, a, 32'd0, 0, 0, '0, tag);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5F1A_0C07);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R2 irq", {31'd0, irq}, 32'd0);
        check("R2 enable", {31'd0, fifo_en}, 32'd0);

        // R2: whole map after reset (R1 write-only addresses read zero)
        for (int a = 0; a < 16; a++) rd(4'(a), (a < 12) ? "R2" : "R1");

        // R3, R4, R5: fill transmit side, then overflow
        wr(A_CTRL, 32'd1);
        for (int i = 0; i < DEPTH; i++) wr(A_TXDAT, 32'hFFFF_A000 + 32'(i));
        rd(A_STAT, "R4");
        rd(A_TXLVL, "R3");
        wr(A_TXDAT, 32'h0000_DEAD);
        rd(A_RAW, "R5");
        rd(A_TXLVL, "R5");
        for (int i = 0; i < DEPTH; i++) step(0, 0, 4'd0, 32'd0, 1, 0, '0);
        rd(A_TXLVL, "R3");

        // R6: read from empty receive FIFO
        rd(A_RXDAT, "R6");
        rd(A_RAW, "R6");

        // R7: overflow the receive FIFO
        for (int i = 0; i < DEPTH + 1; i++) step(0, 0, 4'd0, 32'd0, 0, 1, 16'h5000 + 16'(i));
        rd(A_RAW, "R7");
        rd(A_RXLVL, "R7");
        rd(A_STAT, "R4");

        // R11: clear of rx overflow collides with a new overflow
        step(1, 0, A_CLR, 32'h4, 0, 1, 16'h1111);
        rd(A_RAW, "R11");
        wr(A_CLR, 32'h2);
        rd(A_RAW, "R11");
        wr(A_CLR, 32'h1);
        rd(A_RAW, "R11");

        // R3: receive order
        for (int i = 0; i < DEPTH; i++) rd(A_RXDAT, "R3");

        // R13: thresholds locked while enabled
        wr(A_RXTHR, 32'd3);
        rd(A_RXTHR, "R13");

        // R12: disable flushes and ignores traffic
        wr(A_TXDAT, 32'h1234);
        step(0, 0, 4'd0, 32'd0, 0, 1, 16'h4321);
        wr(A_CTRL, 32'd0);
        step(1, 0, A_TXDAT, 32'h7, 0, 1, 16'h9);
        rd(A_TXLVL, "R12");
        rd(A_RXLVL, "R12");
        rd(A_RAW, "R12");

        // R13: writes accepted while disabled
        wr(A_RXTHR, 32'd3);
        wr(A_TXTHR, 32'd2);
        rd(A_RXTHR, "R13");
        rd(A_TXTHR, "R13");
        wr(A_CTRL, 32'd1);

        // R8: strict greater-than on the receive level
        for (int i = 0; i < 3; i++) step(0, 0, 4'd0, 32'd0, 0, 1, 16'h0A00 + 16'(i));
        rd(A_RAW, "R8");
        step(0, 0, 4'd0, 32'd0, 0, 1, 16'h0AFF);
        rd(A_RAW, "R8");

        // R9: at-or-below on the transmit level
        wr(A_TXDAT, 32'h11);
        wr(A_TXDAT, 32'h22);
        rd(A_RAW, "R9");
        wr(A_TXDAT, 32'h33);
        rd(A_RAW, "R9");

        // R10: mask and pending
        wr(A_MASK, 32'h10);
        rd(A_PEND, "R10");
        check("R10 irq line", {31'd0, irq}, 32'd1);
        wr(A_MASK, 32'h0);
        rd(A_PEND, "R10");

        // R4: busy mirror
        busy = 1;
        rd(A_STAT, "R4");
        busy = 0;

        // random traffic
        for (int n = 0; n < 6000; n++) begin
            int unsigned r = $urandom_range(0, 99);
            bit tp = ($urandom_range(0, 2) == 0);
            bit rp = ($urandom_range(0, 2) == 0);
            logic [DW-1:0] rdat = DW'($urandom);
            busy = $urandom_range(0, 1) == 1;
            if (r < 20)      step(1, 0, A_TXDAT, $urandom, tp, rp, rdat);
            else if (r < 35) step(0, 1, A_RXDAT, 32'd0, tp, rp, rdat);
            else if (r < 45) step(0, 1, 4'($urandom_range(0, 15)), 32'd0, tp, rp, rdat);
            else if (r < 50) step(1, 0, A_CLR, 32'($urandom_range(0, 15)), tp, rp, rdat);
            else if (r < 53) step(1, 0, A_MASK, $urandom, tp, rp, rdat);
            else if (r < 56) step(1, 0, ($urandom_range(0, 1) == 1) ? A_TXTHR : A_RXTHR,
                                  32'($urandom_range(0, 40)), tp, rp, rdat);
            else if (r < 58) step(1, 0, A_CTRL, {31'd0, $urandom_range(0, 4) != 0}, tp, rp, rdat);
            else             step(0, 0, 4'd0, 32'd0, tp, rp, rdat);
        end

        done = 1;
        finish_run();
    end

endmodule